// File: doc/BRIEF.md
# Parallel-Issue Bundle Predecoder

The predecoder looks at an 8-byte window taken from a little-endian instruction stream. It decides whether the instruction at the head of the window opens a 64-bit multi-issue bundle. A bundle is one 32-bit instruction followed by two 16-bit instructions. The block reports the byte length of the head item, which is 2, 4 or 8.

When a bundle is found, the block splits the window into three slots. It clears the multi-issue marker bit in the 32-bit slot, so the ordinary single-instruction decoders can take all three slots unchanged. A parallel tag goes with every slot of the bundle, so downstream legality logic knows those slots came from a bundle. A fault bit is raised for any trailing slot that holds an instruction not allowed there.

The window enters through a valid/ready handshake. The result leaves one cycle later from a registered stage with its own valid/ready handshake. One window can move per cycle.

Top module: `bundle_predecode`

## Requirements
- R1: With word0 = bytes 1:0 of the window, a bundle is detected when word0 bit 11 (mask 0x0800) is 1 and (word0 & 0xE800) != 0xE800; `out_bundle_o` shows the result.
- R2: `out_len_o` is 8 for a bundle. Otherwise it is 4 when word0[15:14] == 2'b11 and 2 in all other cases.
- R3: For a bundle, `slot0_o` equals window bytes 3:0 read as a little-endian 32-bit value with bit 11 forced to 0. For example, bytes 03 C8 00 18 03 92 0B 9C give slot0 = 0x1800C003, slot1 = 0x9203 and slot2 = 0x9C0B.
- R4: Without a bundle, `slot0_o` is bytes 3:0 unchanged for a 32-bit head, or {16'h0, word0} for a 16-bit head. `slot1_o` and `slot2_o` are 0, and `slot_vld_o` is 3'b001.
- R5: For a bundle, `slot1_o` is bytes 5:4 and `slot2_o` is bytes 7:6, both little-endian, and `slot_vld_o` is 3'b111.
- R6: `slot_par_o` is 3'b111 for a bundle and 3'b000 otherwise. Bit i of the bus belongs to slot i.
- R7: `slot_fault_o[i]` (i = 1 or 2) is 1 exactly when the output is a bundle and bits 15:14 of slot i are 2'b11. `slot_fault_o[0]` is always 0.
- R8: `win_ready_o` is 1 when the output stage is empty or `out_ready_i` is 1. While `out_valid_o` is 1 and `out_ready_i` is 0, every output holds its value.
- R9: After reset `out_valid_o` is 0 and every payload output is 0.
- R10: A window accepted at a clock edge appears on the outputs with `out_valid_o` = 1 straight after that edge. If no new window is accepted, a consumed result clears `out_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_valid_i | input | 1 | Fetch window valid |
| win_ready_o | output | 1 | Window accepted when high with valid |
| win_data_i | input | 64 | Window; byte k at bits 8k+7:8k |
| out_valid_o | output | 1 | Decoded result valid |
| out_ready_i | input | 1 | Consumer ready |
| out_bundle_o | output | 1 | Head is a multi-issue bundle |
| out_len_o | output | 4 | Head length in bytes |
| slot0_o | output | 32 | First slot, marker cleared for a bundle |
| slot1_o | output | 16 | Second slot |
| slot2_o | output | 16 | Third slot |
| slot_vld_o | output | 3 | Per-slot valid |
| slot_par_o | output | 3 | Per-slot parallel tag |
| slot_fault_o | output | 3 | Per-slot illegal-in-slot fault |

## Verification
The hardest case to reach is a head word that has the marker bit set and also matches the 0xE800 pattern. It must come out as a plain 32-bit instruction with its marker intact. The second hard case is a bundle with faults in its trailing slots that arrives while the consumer is stalling. Random windows seldom produce either one. The stimulus therefore forces word0 into the 0xE8xx pattern on purpose, and it sets the top two bits of the trailing halfwords on purpose. These windows are mixed into bursts where `out_ready_i` is randomly held low, so faulted bundles also have to survive a stall unchanged.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  parameter int unsigned HALF_W    = 16;
  parameter int unsigned NUM_HALF  = 4;
  parameter int unsigned NUM_SLOTS = 3;
  parameter int unsigned LEN_W     = 4;
  localparam int unsigned WIN_W    = HALF_W * NUM_HALF;
  localparam int unsigned WIDE_W   = 2 * HALF_W;
  localparam int unsigned MARK_BIT = 11;
  localparam logic [HALF_W-1:0] EXCL_MASK = 16'hE800;

  typedef struct packed {
    logic                 bundle;
    logic [LEN_W-1:0]     len;
    logic [WIDE_W-1:0]    slot0;
    logic [HALF_W-1:0]    slot1;
    logic [HALF_W-1:0]    slot2;
    logic [NUM_SLOTS-1:0] vld;
    logic [NUM_SLOTS-1:0] par;
    logic [NUM_SLOTS-1:0] fault;
  } pre_t;
endpackage

// File: rtl/bpd_slot_check.sv
module bpd_slot_check
  import bpd_pkg::*;
(
  input  logic [HALF_W-1:0] hw_i,
  input  logic              in_bundle_i,
  output logic              illegal_o
);
  // a halfword opening a 32-bit op cannot sit in a 16-bit trailing slot
  assign illegal_o = in_bundle_i && (hw_i[HALF_W-1 -: 2] == 2'b11);
endmodule

// File: rtl/bpd_window_split.sv
module bpd_window_split
  import bpd_pkg::*;
(
  input  logic [WIN_W-1:0] win_i,
  output pre_t             pre_o
);
  logic [HALF_W-1:0] hw [NUM_HALF];
  logic              is_bundle;
  logic              is_wide;
  logic [NUM_SLOTS-1:0] flt;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_hw
    assign hw[h] = win_i[h*HALF_W +: HALF_W];
  end

  assign is_bundle = hw[0][MARK_BIT] && ((hw[0] & EXCL_MASK) != EXCL_MASK);
  assign is_wide   = (hw[0][HALF_W-1 -: 2] == 2'b11);

  assign flt[0] = 1'b0;
  for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_chk
    bpd_slot_check u_chk (
      .hw_i        (hw[s+1]),
      .in_bundle_i (is_bundle),
      .illegal_o   (flt[s])
    );
  end

  always_comb begin
    pre_o        = '0;
    pre_o.bundle = is_bundle;
    pre_o.fault  = flt;
    if (is_bundle) begin
      pre_o.len              = LEN_W'(8);
      pre_o.slot0            = {hw[1], hw[0]};
      pre_o.slot0[MARK_BIT]  = 1'b0;
      pre_o.slot1            = hw[2];
      pre_o.slot2            = hw[3];
      pre_o.vld              = '1;
      pre_o.par              = '1;
    end else if (is_wide) begin
      pre_o.len   = LEN_W'(4);
      pre_o.slot0 = {hw[1], hw[0]};
      pre_o.vld   = NUM_SLOTS'(1);
    end else begin
      pre_o.len   = LEN_W'(2);
      pre_o.slot0 = {{HALF_W{1'b0}}, hw[0]};
      pre_o.vld   = NUM_SLOTS'(1);
    end
  end
endmodule

// File: rtl/bpd_out_stage.sv
module bpd_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] q_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign ready_o = !vld_q || ready_i;
  assign valid_o = vld_q;
  assign q_o     = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (valid_i && ready_o) begin
      vld_q <= 1'b1;
      dat_q <= d_i;
    end else if (ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !ready_i |=> vld_q && $stable(dat_q));
  assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> vld_q);
  assert_drain_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && ready_i && !valid_i |=> !vld_q);
endmodule

// File: rtl/bundle_predecode.sv
module bundle_predecode
  import bpd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 win_valid_i,
  output logic                 win_ready_o,
  input  logic [WIN_W-1:0]     win_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic                 out_bundle_o,
  output logic [LEN_W-1:0]     out_len_o,
  output logic [WIDE_W-1:0]    slot0_o,
  output logic [HALF_W-1:0]    slot1_o,
  output logic [HALF_W-1:0]    slot2_o,
  output logic [NUM_SLOTS-1:0] slot_vld_o,
  output logic [NUM_SLOTS-1:0] slot_par_o,
  output logic [NUM_SLOTS-1:0] slot_fault_o
);
  localparam int unsigned PW = $bits(pre_t);

  pre_t          pre_d;
  pre_t          pre_q;
  logic [PW-1:0] q_bits;

  bpd_window_split u_split (
    .win_i (win_data_i),
    .pre_o (pre_d)
  );

  bpd_out_stage #(.W(PW)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (win_valid_i),
    .ready_o (win_ready_o),
    .d_i     (pre_d),
    .valid_o (out_valid_o),
    .ready_i (out_ready_i),
    .q_o     (q_bits)
  );

  assign pre_q        = pre_t'(q_bits);
  assign out_bundle_o = pre_q.bundle;
  assign out_len_o    = pre_q.len;
  assign slot0_o      = pre_q.slot0;
  assign slot1_o      = pre_q.slot1;
  assign slot2_o      = pre_q.slot2;
  assign slot_vld_o   = pre_q.vld;
  assign slot_par_o   = pre_q.par;
  assign slot_fault_o = pre_q.fault;

  assert_bundle_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_bundle_o |-> out_len_o == LEN_W'(8));
  assert_marker_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_bundle_o |-> !slot0_o[MARK_BIT]);
  assert_single_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_bundle_o |-> slot_vld_o == NUM_SLOTS'(1) && slot1_o == '0);
  assert_par_tag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> slot_par_o == (out_bundle_o ? slot_vld_o : '0));
  assert_no_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_bundle_o |-> slot_fault_o == '0);
  assert_head_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !slot_fault_o[0]);
endmodule

// File: tb/bundle_predecode_bench.sv
module bundle_predecode_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        bundle;
    logic [3:0]  len;
    logic [31:0] s0;
    logic [15:0] s1;
    logic [15:0] s2;
    logic [2:0]  vld;
    logic [2:0]  par;
    logic [2:0]  flt;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_valid = 1'b0;
  logic        win_ready;
  logic [63:0] win_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_bundle;
  logic [3:0]  out_len;
  logic [31:0] slot0;
  logic [15:0] slot1, slot2;
  logic [2:0]  svld, spar, sflt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit   m_valid = 0;
  exp_t m_rec   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bundle_predecode u_bundle_predecode (
    .clk_i(clk), .rst_ni(rst_n),
    .win_valid_i(win_valid), .win_ready_o(win_ready), .win_data_i(win_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_bundle_o(out_bundle), .out_len_o(out_len),
    .slot0_o(slot0), .slot1_o(slot1), .slot2_o(slot2),
    .slot_vld_o(svld), .slot_par_o(spar), .slot_fault_o(sflt)
  );

  function automatic exp_t calc(input logic [63:0] d);
    exp_t e = '0;
    logic [15:0] w0 = d[15:0];
    bit b = (w0 & 16'h0800) != 0 && (w0 & 16'hE800) != 16'hE800;
    e.bundle = b;
    if (b) begin
      e.len = 8; e.s0 = d[31:0] & ~32'h0000_0800;
      e.s1 = d[47:32]; e.s2 = d[63:48];
      e.vld = 3'b111; e.par = 3'b111;
      e.flt = {d[63:62] == 2'b11, d[47:46] == 2'b11, 1'b0};
    end else if (w0[15:14] == 2'b11) begin
      e.len = 4; e.s0 = d[31:0]; e.vld = 3'b001;
    end else begin
      e.len = 2; e.s0 = {16'h0, w0}; e.vld = 3'b001;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk("R10 out_valid", 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      chk("R1 bundle", 64'(out_bundle), 64'(m_rec.bundle));
      chk("R2 len", 64'(out_len), 64'(m_rec.len));
      chk(m_rec.bundle ? "R3 slot0" : "R4 slot0", 64'(slot0), 64'(m_rec.s0));
      chk(m_rec.bundle ? "R5 slot1/2" : "R4 slot1/2", {32'h0, slot1, slot2}, {32'h0, m_rec.s1, m_rec.s2});
      chk(m_rec.bundle ? "R5 vld" : "R4 vld", 64'(svld), 64'(m_rec.vld));
      chk("R6 par", 64'(spar), 64'(m_rec.par));
      chk("R7 fault", 64'(sflt), 64'(m_rec.flt));
    end
  endtask

  // one cycle: check at negedge, apply inputs, step model
  task automatic cycle(input bit v, input logic [63:0] d, input bit rdy);
    @(negedge clk);
    compare_outputs();
    win_valid = v; win_data = d; out_ready = rdy;
    #1;
    chk("R8 win_ready", 64'(win_ready), 64'(!m_valid || rdy));
    if (v && (!m_valid || rdy)) begin
      m_valid = 1; m_rec = calc(d);
    end else if (rdy) begin
      m_valid = 0;
    end
  endtask

  function automatic logic [63:0] rand_win();
    logic [63:0] d = {$urandom, $urandom};
    int k = $urandom_range(0, 5);
    if (k < 3) d[11] = 1'b1;
    if (k == 3) d[15:11] = 5'b11101;
    if ($urandom_range(0, 2) == 0) d[47:46] = 2'b11;
    if ($urandom_range(0, 2) == 0) d[63:62] = 2'b11;
    return d;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset valid", 64'(out_valid), 64'h0);
    chk("R9 reset payload", {slot0, slot1, slot2}, 64'h0);
    chk("R9 reset flags", {51'h0, out_bundle, out_len, svld, spar, sflt}, 64'h0);
    rst_n = 1'b1;
    // R3 reference vector, bytes 03 C8 00 18 03 92 0B 9C
    cycle(1, 64'h9C0B_9203_1800_C803, 1);
    cycle(0, '0, 1);
    // R1 marker with E800 pattern: no bundle, 32-bit
    cycle(1, 64'hC000_1234_5678_E803, 1);
    // R4 16-bit head, 32-bit head
    cycle(1, 64'hFFFF_FFFF_AAAA_1234, 1);
    cycle(1, 64'h0000_0000_ABCD_C123, 1);
    // R7 faults in both trailing slots
    cycle(1, 64'hC001_D002_0000_0800, 1);
    cycle(1, 64'h4000_C000_0000_0800, 1);
    // R8 stall holding a faulted bundle
    cycle(1, 64'hFFFF_FFFF_FFFF_0801, 0);
    cycle(1, 64'h1111_2222_3333_4444, 0);
    cycle(0, '0, 0);
    cycle(0, '0, 1);
    cycle(0, '0, 1);
    for (int i = 0; i < 3000; i++)
      cycle($urandom_range(0, 3) != 0, rand_win(), $urandom_range(0, 2) != 0);
    cycle(0, '0, 1);
    cycle(0, '0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule